// File: doc/BRIEF.md
# Prioritised Interrupt Routing Controller

This block gathers level-sensitive interrupt requests from up to 32 sources and routes them to up to four processor contexts through a word-addressed register port. Each source carries a 3-bit priority. Each context has its own mask of source enables, a 3-bit threshold and one claim/complete register. A context's interrupt line is raised whenever some source that is pending and enabled for that context has a priority strictly above that context's threshold.

Software services an interrupt in two steps. A read of the context's claim register returns the best eligible source and removes it from the pending set in that same access. The source then counts as in service, and it cannot become pending again until software writes its ID back to the same register. Source ID 0 is reserved. A claim that finds nothing eligible returns 0, so a handler can keep claiming until it reads 0.

Top module: `irq_hub`

## Requirements
- R1: After reset every priority, enable and threshold register reads 0, every interrupt output is low and a claim read returns 0.
- R2: The priority of source n is at byte offset 4*n. It holds 3 bits, and bits 31:3 read as 0. The entry for ID 0 always reads 0 and ignores writes.
- R3: The enable word of context c is at offset 0x2000 + 0x80*c. Bit n enables source n for that context. Bit 0 always reads 0.
- R4: Context c has its threshold (3 bits, upper bits read 0) at offset 0x200000 + 0x1000*c and its claim/complete register at that offset + 4.
- R5: The output of context c is high exactly when some source is pending, enabled for c, and has a priority strictly above c's threshold. It follows the pending state with one register stage.
- R6: A threshold of 7 keeps the context's output low and its claims at 0. A source with priority 0 is never delivered.
- R7: A claim read returns the eligible source with the highest priority, the lowest ID winning a tie. In the same access that source stops being pending and becomes in service.
- R8: Claims issued one after another each return the next best eligible source, and they return 0 once none remains.
- R9: A source in service does not become pending again, even with its request held high, until its own ID is written to a claim/complete register. A completion carrying an ID that is not in service has no effect.
- R10: A source becomes pending on any clock edge where its request is high and it is neither pending nor in service. It stays pending after its request drops, until it is claimed.
- R11: A read of an unmapped offset returns 0, and a write to one changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_req | input | NSRC | Level request per source (bit 0 unused) |
| bus_rd | input | 1 | Read strobe, data returned the following cycle |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 22 | Byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data, zero when no read took place |
| ctx_irq | output | NCTX | Registered interrupt line per context |

## Verification
The hardest case to reach from the ports is a source that holds its request high while it is in service. Such a source must stay out of both claims and the interrupt output until its own completion arrives. A completion for some other ID must change nothing. The bench holds every request high through a sweep of 8 priority patterns, including an all-tie pattern, against all 8 thresholds. In each step it drains the context by claiming until it reads 0 and then completes every claimed ID, so each completion leads straight to a new pending edge. A reference model in the bench predicts every result. Directed steps then apply a stray completion and a one-cycle request pulse.

// File: rtl/irq_hub_pkg.sv
package irq_hub_pkg;
  localparam int ADDR_W     = 22;
  localparam int DATA_W     = 32;
  localparam int EN_BASE    = 32'h0000_2000;
  localparam int EN_STRIDE  = 32'h80;
  localparam int CTX_BASE   = 32'h0020_0000;
  localparam int CTX_STRIDE = 32'h1000;
  localparam int CLAIM_OFS  = 4;

  function automatic int id_width(input int n);
    return (n <= 2) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/irq_hub_gate.sv
module irq_hub_gate #(
  parameter int NSRC = 32,
  parameter int IDW  = 5
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] src_req,
  input  logic            take_en,
  input  logic [IDW-1:0]  take_id,
  input  logic            done_en,
  input  logic [IDW-1:0]  done_id,
  output logic [NSRC-1:0] pending,
  output logic [NSRC-1:0] in_service
);
  assign pending[0]    = 1'b0;
  assign in_service[0] = 1'b0;

  for (genvar i = 1; i < NSRC; i++) begin : g_src
    logic pend_q, svc_q;
    always_ff @(posedge clk) begin
      if (rst) begin
        pend_q <= 1'b0;
        svc_q  <= 1'b0;
      end else begin
        if (take_en && take_id == IDW'(i)) begin
          pend_q <= 1'b0;
          svc_q  <= 1'b1;
        end else begin
          if (src_req[i] && !pend_q && !svc_q) pend_q <= 1'b1;
          if (done_en && done_id == IDW'(i)) svc_q <= 1'b0;
        end
      end
    end
    assign pending[i]    = pend_q;
    assign in_service[i] = svc_q;
  end

  p_excl_r10: assert property (@(posedge clk) disable iff (rst)
    (pending & in_service) == '0);
  p_take_r7: assert property (@(posedge clk) disable iff (rst)
    (take_en && take_id != '0) |=> (in_service[$past(take_id)] && !pending[$past(take_id)]));
  p_done_r9: assert property (@(posedge clk) disable iff (rst)
    (done_en && done_id != '0 && in_service[done_id]) |=> !in_service[$past(done_id)]);
endmodule

// File: rtl/irq_hub_arb.sv
module irq_hub_arb #(
  parameter int NSRC = 32,
  parameter int PW   = 3,
  parameter int IDW  = 5
) (
  input  logic [NSRC-1:0]    pending,
  input  logic [NSRC-1:0]    enable,
  input  logic [NSRC*PW-1:0] prio_flat,
  input  logic [PW-1:0]      thr,
  output logic [IDW-1:0]     best_id,
  output logic               best_ok
);
  logic [PW-1:0] best_p;

  always_comb begin
    best_id = '0;
    best_ok = 1'b0;
    best_p  = thr;
    for (int i = 1; i < NSRC; i++) begin
      if (pending[i] && enable[i] && prio_flat[i*PW +: PW] > best_p) begin
        best_p  = prio_flat[i*PW +: PW];
        best_id = IDW'(i);
        best_ok = 1'b1;
      end
    end
  end
endmodule

// File: rtl/irq_hub.sv
module irq_hub
  import irq_hub_pkg::*;
#(
  parameter int NSRC = 32,
  parameter int NCTX = 2,
  parameter int PW   = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NSRC-1:0]   src_req,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [NCTX-1:0]   ctx_irq
);
  localparam int IDW = id_width(NSRC);
  localparam int CW  = (NCTX <= 1) ? 1 : $clog2(NCTX);
  localparam int WW  = ADDR_W - 2;

  logic [PW-1:0]     prio_q [NSRC];
  logic [NSRC-1:0]   en_q   [NCTX];
  logic [PW-1:0]     thr_q  [NCTX];
  logic [NSRC*PW-1:0] prio_flat;
  logic [NSRC-1:0]   pending, in_service;
  logic [IDW-1:0]    best_id [NCTX];
  logic [NCTX-1:0]   best_ok;

  logic [WW-1:0]     word;
  logic              hit_prio;
  logic [IDW-1:0]    prio_idx;
  logic [NCTX-1:0]   hit_en, hit_thr, hit_clm;
  logic [CW-1:0]     clm_ctx;
  logic              take_en, done_en;
  logic [IDW-1:0]    take_id, done_id;
  logic              any_hit;
  logic [DATA_W-1:0] rd_val;

  assign word     = bus_addr[ADDR_W-1:2];
  assign hit_prio = (word < WW'(NSRC));
  assign prio_idx = bus_addr[IDW+1:2];

  for (genvar c = 0; c < NCTX; c++) begin : g_dec
    localparam logic [WW-1:0] EN_W  = WW'((EN_BASE + c*EN_STRIDE) >> 2);
    localparam logic [WW-1:0] THR_W = WW'((CTX_BASE + c*CTX_STRIDE) >> 2);
    localparam logic [WW-1:0] CLM_W = WW'((CTX_BASE + c*CTX_STRIDE + CLAIM_OFS) >> 2);
    assign hit_en[c]  = (word == EN_W);
    assign hit_thr[c] = (word == THR_W);
    assign hit_clm[c] = (word == CLM_W);
  end

  for (genvar i = 0; i < NSRC; i++) begin : g_flat
    assign prio_flat[i*PW +: PW] = prio_q[i];
  end

  always_comb begin
    clm_ctx = '0;
    for (int c = 0; c < NCTX; c++) if (hit_clm[c]) clm_ctx = CW'(c);
  end

  assign any_hit = hit_prio | (|hit_en) | (|hit_thr) | (|hit_clm);
  assign take_en = bus_rd && (|hit_clm) && best_ok[clm_ctx];
  assign take_id = best_ok[clm_ctx] ? best_id[clm_ctx] : '0;
  assign done_en = bus_wr && (|hit_clm) && (bus_wdata < DATA_W'(NSRC));
  assign done_id = bus_wdata[IDW-1:0];

  irq_hub_gate #(.NSRC(NSRC), .IDW(IDW)) u_gate (
    .clk(clk), .rst(rst), .src_req(src_req),
    .take_en(take_en), .take_id(take_id),
    .done_en(done_en), .done_id(done_id),
    .pending(pending), .in_service(in_service)
  );

  for (genvar c = 0; c < NCTX; c++) begin : g_ctx
    irq_hub_arb #(.NSRC(NSRC), .PW(PW), .IDW(IDW)) u_arb (
      .pending(pending), .enable(en_q[c]), .prio_flat(prio_flat),
      .thr(thr_q[c]), .best_id(best_id[c]), .best_ok(best_ok[c])
    );

    always_ff @(posedge clk) begin
      if (rst) begin
        en_q[c]    <= '0;
        thr_q[c]   <= '0;
        ctx_irq[c] <= 1'b0;
      end else begin
        ctx_irq[c] <= best_ok[c];
        if (bus_wr && hit_en[c])  en_q[c]  <= bus_wdata[NSRC-1:0] & ~NSRC'(1);
        if (bus_wr && hit_thr[c]) thr_q[c] <= bus_wdata[PW-1:0];
      end
    end

    p_mask_r6: assert property (@(posedge clk) disable iff (rst)
      (thr_q[c] == '1) |=> !ctx_irq[c]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NSRC; i++) prio_q[i] <= '0;
    end else if (bus_wr && hit_prio && prio_idx != '0) begin
      prio_q[prio_idx] <= bus_wdata[PW-1:0];
    end
  end

  always_comb begin
    rd_val = '0;
    if (hit_prio) rd_val = DATA_W'(prio_q[prio_idx]);
    for (int c = 0; c < NCTX; c++) begin
      if (hit_en[c])  rd_val = DATA_W'(en_q[c]);
      if (hit_thr[c]) rd_val = DATA_W'(thr_q[c]);
      if (hit_clm[c]) rd_val = DATA_W'(take_id);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else     bus_rdata <= bus_rd ? rd_val : '0;
  end

  p_unmapped_r11: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && !any_hit) |=> bus_rdata == '0);
endmodule

// File: tb/irq_hub_tb.sv
module irq_hub_tb;
  localparam int NS = 8;
  localparam int NC = 2;

  logic        clk = 0;
  logic        rst = 1;
  logic [NS-1:0] src_req = '0;
  logic        bus_rd = 0, bus_wr = 0;
  logic [21:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [NC-1:0] ctx_irq;

  irq_hub #(.NSRC(NS), .NCTX(NC), .PW(3)) u_dut (
    .clk(clk), .rst(rst), .src_req(src_req), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ctx_irq(ctx_irq)
  );

  always #5 clk = ~clk;

  int tests = 0, fails = 0;
  bit done_flag = 0;

  int m_prio [NS];
  logic [NS-1:0] m_en [NC];
  int m_thr [NC];
  logic [NS-1:0] m_pend = '0, m_insv = '0;

  function automatic logic [21:0] a_prio(int i); return 22'(i*4); endfunction
  function automatic logic [21:0] a_en(int c);   return 22'(32'h2000 + c*32'h80); endfunction
  function automatic logic [21:0] a_thr(int c);  return 22'(32'h200000 + c*32'h1000); endfunction
  function automatic logic [21:0] a_clm(int c);  return 22'(32'h200004 + c*32'h1000); endfunction

  function automatic int best(int c);
    int b = 0, bp = m_thr[c];
    for (int i = 1; i < NS; i++)
      if (m_pend[i] && m_en[c][i] && m_prio[i] > bp) begin bp = m_prio[i]; b = i; end
    return b;
  endfunction

  task automatic refresh();
    m_pend = m_pend | (src_req & ~m_insv & 8'hFE);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [21:0] a, input logic [31:0] d);
    @(negedge clk); bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 0;
    refresh();
  endtask

  task automatic rd(input logic [21:0] a, output logic [31:0] d);
    @(negedge clk); bus_rd = 1; bus_addr = a;
    @(negedge clk); bus_rd = 0; d = bus_rdata;
    refresh();
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
    refresh();
  endtask

  task automatic claim(input int c, input string tag, output int got);
    logic [31:0] d;
    int e = best(c);
    rd(a_clm(c), d);
    chk(tag, d, 32'(e));
    if (e != 0) begin m_pend[e] = 1'b0; m_insv[e] = 1'b1; end
    refresh();
    got = int'(d);
  endtask

  task automatic complete(input int c, input int id);
    wr(a_clm(c), 32'(id));
    if (id > 0 && id < NS) m_insv[id] = 1'b0;
    refresh();
  endtask

  initial begin
    for (int k = 0; k < 150000; k++) @(posedge clk);
    if (!done_flag) begin
      fails++; tests++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    int got;
    int ids [NS];
    int n;
    for (int i = 0; i < NS; i++) m_prio[i] = 0;
    for (int c = 0; c < NC; c++) begin m_en[c] = '0; m_thr[c] = 0; end
    repeat (3) @(negedge clk);
    rst = 0;

    // R1 reset state
    chk("R1 irq", 32'(ctx_irq), 0);
    rd(a_prio(3), d); chk("R1 prio", d, 0);
    rd(a_en(1), d);   chk("R1 en", d, 0);
    rd(a_thr(0), d);  chk("R1 thr", d, 0);
    claim(0, "R1 claim", got);

    // R2 priority map
    wr(a_prio(3), 32'hFF); m_prio[3] = 7;
    rd(a_prio(3), d); chk("R2 prio width", d, 7);
    wr(a_prio(0), 5);
    rd(a_prio(0), d); chk("R2 id0", d, 0);
    wr(a_prio(3), 0); m_prio[3] = 0;
    rd(a_prio(3), d); chk("R2 rewrite", d, 0);
    // R3 enable map
    wr(a_en(0), 32'hFFFF_FFFF); m_en[0] = 8'hFE;
    rd(a_en(0), d); chk("R3 en0", d, 32'hFE);
    rd(a_en(1), d); chk("R3 en1 separate", d, 0);
    // R4 threshold
    wr(a_thr(1), 32'hA); m_thr[1] = 2;
    rd(a_thr(1), d); chk("R4 thr", d, 2);
    rd(a_thr(0), d); chk("R4 thr0", d, 0);
    // R11 unmapped
    wr(22'h1000, 32'h5); wr(22'h2100, 32'h5); wr(22'h200008, 32'h5);
    rd(22'h1000, d);   chk("R11 rd gap", d, 0);
    rd(22'h200008, d); chk("R11 rd ctx gap", d, 0);
    rd(a_en(0), d);    chk("R11 en untouched", d, 32'hFE);
    rd(a_thr(0), d);   chk("R11 thr untouched", d, 0);

    // Sweep R5 R6 R7 R8: 8 priority patterns x 8 thresholds, all requests high
    src_req = 8'hFE;
    wr(a_en(1), 32'hAA); m_en[1] = 8'hAA;
    for (int p = 0; p < 8; p++) begin
      for (int i = 1; i < NS; i++) begin
        m_prio[i] = (i*p + 3) % 8;
        wr(a_prio(i), 32'(m_prio[i]));
      end
      for (int t = 0; t < 8; t++) begin
        wr(a_thr(0), 32'(t)); m_thr[0] = t;
        idle(3);
        chk("R5 irq0", 32'(ctx_irq[0]), 32'(best(0) != 0));
        chk("R5 irq1", 32'(ctx_irq[1]), 32'(best(1) != 0));
        if (t == 7) chk("R6 masked", 32'(ctx_irq[0]), 0);
        n = 0;
        for (int k = 0; k < NS; k++) begin
          claim(0, "R7 R8 claim", got);
          if (got == 0) break;
          ids[n] = got; n++;
        end
        claim(1, "R7 ctx1 claim", got);
        if (got != 0) begin ids[n] = got; n++; end
        for (int k = 0; k < n; k++) complete(0, ids[k]);
      end
    end

    // R9 in-service hold and stray completion
    src_req = '0;
    for (int i = 1; i < NS; i++) begin m_prio[i] = 0; wr(a_prio(i), 0); end
    wr(a_thr(0), 0); m_thr[0] = 0;
    wr(a_prio(5), 4); m_prio[5] = 4;
    src_req = 8'h20; idle(2);
    claim(0, "R9 first", got); chk("R9 got5", 32'(got), 5);
    idle(3);
    claim(0, "R9 no repend", got); chk("R9 zero", 32'(got), 0);
    chk("R9 irq low", 32'(ctx_irq[0]), 0);
    complete(0, 3); idle(3);
    chk("R9 stray ignored irq", 32'(ctx_irq[0]), 0);
    claim(0, "R9 stray ignored", got);
    complete(0, 5); idle(3);
    chk("R9 repend irq", 32'(ctx_irq[0]), 1);
    claim(0, "R9 after done", got); chk("R9 got5 again", 32'(got), 5);
    src_req = '0; complete(0, 5);

    // R10 one-cycle pulse stays pending
    wr(a_prio(6), 2); m_prio[6] = 2;
    @(negedge clk); src_req = 8'h40;
    @(negedge clk); src_req = '0;
    m_pend = m_pend | (8'h40 & ~m_insv);
    idle(3);
    chk("R10 irq held", 32'(ctx_irq[0]), 1);
    claim(0, "R10 claim", got); chk("R10 got6", 32'(got), 6);
    complete(0, 6); idle(3);
    chk("R10 drained", 32'(ctx_irq[0]), 0);
    // R6 priority zero never delivered
    wr(a_prio(6), 0); m_prio[6] = 0;
    src_req = 8'h40; idle(3);
    chk("R6 prio0 irq", 32'(ctx_irq[0]), 0);
    claim(0, "R6 prio0 claim", got);

    done_flag = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule